// File: doc/BRIEF.md
# SD Host Single-Buffer DMA Channel

This block moves one contiguous buffer between system memory and the data path of an SD host. Software programs a mode word (which way the data goes, how wide each beat is, whether the address steps or stays put), a 64-bit buffer address written as two 32-bit halves, and then sets a start bit that clears itself. The transfer length comes from the host's block count and block size inputs. It is turned into a beat count by rounding the byte total up to whole beats.

On the memory side the engine issues word requests that are held until granted. For reads, data returns in the grant cycle. On the card side it drives an outgoing valid/ready stream (memory to card) or accepts an incoming one (card to memory). A single holding register sits between the two sides. The engine raises a one-cycle done pulse once the last beat has left the holding register. Each direction has an active-low soft reset bit. Clearing the bit of the running direction abandons the transfer at once.

Top module: `sddma_channel`

## Requirements
- R1: The mode register at offset 0x00 keeps direction in bits [17:16] (0 memory to card, 1 card to memory), a width code in bits [5:4] (0, 1, 2, 3 for 1, 2, 4, 8 bytes per beat) and the increment flag in bit 0. All other bits read back as 0, so writing all ones reads back 0x00030031.
- R2: The buffer address is written as a low word at offset 0x10 and a high word at offset 0x14, and both read back as written. All registers except the channel reset register read 0 after reset.
- R3: Writing 1 to bit 0 of the control register at offset 0x04 starts a transfer, and that bit reads back as 0 from the cycle after the write.
- R4: A transfer moves exactly ceil(blk_count*blk_size / beat bytes) beats across both the memory side and the stream side.
- R5: In direction 0, each word read from memory appears on tx_data in the order it was fetched.
- R6: In direction 1, each word accepted on rx_data is written to memory (mem_we high) in arrival order.
- R7: With the increment flag set, mem_addr advances by the beat size after each granted memory beat, carrying across the full 64 bits. With the flag clear, mem_addr stays at the start address.
- R8: done is high for exactly one cycle after the last beat leaves the holding register, and busy is low from that same cycle.
- R9: A start is ignored, so that busy stays low and no memory request appears, when the buffer address is not 8-byte aligned, when the beat count is zero, or when the direction field is 2 or 3.
- R10: The channel reset register at offset 0x08 holds bit 8 for the memory-to-card channel and bit 9 for the card-to-memory channel, and both are 1 after reset. Clearing the bit of the running direction ends the transfer with busy low, no further beats and no done pulse. A start for a direction whose bit is 0 is ignored.
- R11: Once raised, mem_req stays high with an unchanged mem_addr until mem_gnt, unless the transfer is aborted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| blk_count | input | 16 | Number of blocks in the transfer |
| blk_size | input | 12 | Bytes per block |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | Memory beat is a write |
| mem_addr | output | 64 | Memory beat byte address |
| mem_size | output | 2 | Beat width code |
| mem_wdata | output | 64 | Memory write data |
| mem_gnt | input | 1 | Memory accepts the beat |
| mem_rdata | input | 64 | Read data, valid in the grant cycle |
| tx_valid | output | 1 | Outgoing stream word valid |
| tx_ready | input | 1 | Outgoing stream ready |
| tx_data | output | 64 | Outgoing stream word |
| rx_valid | input | 1 | Incoming stream word valid |
| rx_ready | output | 1 | Incoming stream ready |
| rx_data | input | 64 | Incoming stream word |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions guard, on every cycle, the properties that hold locally in time. The start bit clears itself, done never lasts two cycles, an ungranted request holds its address, an incrementing beat moves the address by the beat size, a misaligned start leaves the engine idle, and an abort returns it to idle without a done pulse. Other properties only the bench's scenarios can show: that the beat total matches the block geometry for every width, that data keeps its order through the holding register in both directions, that stepping stops at a fixed address, and that beats stop after a channel reset while the register stays readable.

// File: rtl/sddma_pkg.sv
package sddma_pkg;

    localparam int REG_AW = 8;

    // register byte offsets
    localparam logic [REG_AW-1:0] OFS_MODE    = 8'h00;
    localparam logic [REG_AW-1:0] OFS_CTRL    = 8'h04;
    localparam logic [REG_AW-1:0] OFS_CHRST   = 8'h08;
    localparam logic [REG_AW-1:0] OFS_ADDR_LO = 8'h10;
    localparam logic [REG_AW-1:0] OFS_ADDR_HI = 8'h14;

    // field positions
    localparam int MODE_DIR_LSB = 16;
    localparam int MODE_WID_LSB = 4;
    localparam int MODE_INC_BIT = 0;
    localparam int CTRL_GO_BIT  = 0;
    localparam int CHRST_LSB    = 8;
    localparam int ALIGN_BITS   = 3;

    typedef enum logic [1:0] {
        WID_8  = 2'd0,
        WID_16 = 2'd1,
        WID_32 = 2'd2,
        WID_64 = 2'd3
    } wid_e;

    typedef struct packed {
        logic [1:0] dir;
        wid_e       wid;
        logic       inc;
    } mode_t;

    function automatic logic [3:0] beat_bytes(input wid_e w);
        return 4'd1 << w;
    endfunction

    function automatic logic [31:0] mode_word(input mode_t m);
        logic [31:0] v;
        v = '0;
        v[MODE_DIR_LSB +: 2] = m.dir;
        v[MODE_WID_LSB +: 2] = m.wid;
        v[MODE_INC_BIT]      = m.inc;
        return v;
    endfunction

endpackage

// File: rtl/sddma_regs.sv
module sddma_regs
    import sddma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output mode_t             mode,
    output logic [63:0]       start_addr,
    output logic              go,
    output logic [1:0]        ch_run
);

    mode_t       mode_q;
    logic [31:0] lo_q, hi_q;
    logic        go_q;
    logic [1:0]  run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            lo_q   <= '0;
            hi_q   <= '0;
            go_q   <= 1'b0;
            run_q  <= 2'b11;
        end else begin
            go_q <= 1'b0;
            if (wr_en) begin
                case (addr)
                    OFS_MODE: begin
                        mode_q.dir <= wdata[MODE_DIR_LSB +: 2];
                        mode_q.wid <= wid_e'(wdata[MODE_WID_LSB +: 2]);
                        mode_q.inc <= wdata[MODE_INC_BIT];
                    end
                    OFS_CTRL:    go_q  <= wdata[CTRL_GO_BIT];
                    OFS_CHRST:   run_q <= wdata[CHRST_LSB +: 2];
                    OFS_ADDR_LO: lo_q  <= wdata;
                    OFS_ADDR_HI: hi_q  <= wdata;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            OFS_MODE:    rdata = mode_word(mode_q);
            OFS_CTRL:    rdata[CTRL_GO_BIT] = go_q;
            OFS_CHRST:   rdata[CHRST_LSB +: 2] = run_q;
            OFS_ADDR_LO: rdata = lo_q;
            OFS_ADDR_HI: rdata = hi_q;
            default:     rdata = '0;
        endcase
    end

    assign mode       = mode_q;
    assign start_addr = {hi_q, lo_q};
    assign go         = go_q;
    assign ch_run     = run_q;

    AST_GO_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (go_q && !(wr_en && addr == OFS_CTRL && wdata[CTRL_GO_BIT])) |=> !go_q); // R3

endmodule

// File: rtl/sddma_engine.sv
module sddma_engine
    import sddma_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int BSZ_W  = 12,
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  mode_t             mode,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [1:0]        ch_run,
    input  logic [CNT_W-1:0]  blk_count,
    input  logic [BSZ_W-1:0]  blk_size,
    input  logic              in_fire,
    input  logic              out_fire,
    input  logic              mem_fire,
    output logic              active,
    output logic              dir,
    output wid_e              wid,
    output logic [ADDR_W-1:0] addr,
    output logic              can_take,
    output logic              abort,
    output logic              done
);

    localparam int LEN_W = CNT_W + BSZ_W + 1;

    logic              active_q, dir_q, inc_q, done_q;
    wid_e              wid_q;
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  issue_left_q, done_left_q;

    logic [LEN_W-1:0]  req_bytes, req_beats;
    logic              launch_ok;

    always_comb begin
        req_bytes = LEN_W'(blk_count) * LEN_W'(blk_size);
        req_beats = (req_bytes + LEN_W'(beat_bytes(mode.wid)) - LEN_W'(1)) >> mode.wid;
        launch_ok = (start_addr[ALIGN_BITS-1:0] == '0) && (req_beats != '0)
                    && !mode.dir[1] && ch_run[mode.dir[0]];
    end

    assign abort    = active_q && !ch_run[dir_q];
    assign can_take = active_q && !abort && (issue_left_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q     <= 1'b0;
            dir_q        <= 1'b0;
            inc_q        <= 1'b0;
            wid_q        <= WID_8;
            addr_q       <= '0;
            issue_left_q <= '0;
            done_left_q  <= '0;
            done_q       <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (abort) begin
                active_q     <= 1'b0;
                issue_left_q <= '0;
                done_left_q  <= '0;
            end else if (active_q) begin
                if (in_fire)
                    issue_left_q <= issue_left_q - LEN_W'(1);
                if (mem_fire && inc_q)
                    addr_q <= addr_q + ADDR_W'(beat_bytes(wid_q));
                if (out_fire) begin
                    done_left_q <= done_left_q - LEN_W'(1);
                    if (done_left_q == LEN_W'(1)) begin
                        active_q <= 1'b0;
                        done_q   <= 1'b1;
                    end
                end
            end else if (go && launch_ok) begin
                active_q     <= 1'b1;
                dir_q        <= mode.dir[0];
                wid_q        <= mode.wid;
                inc_q        <= mode.inc;
                addr_q       <= start_addr;
                issue_left_q <= req_beats;
                done_left_q  <= req_beats;
            end
        end
    end

    assign active = active_q;
    assign dir    = dir_q;
    assign wid    = wid_q;
    assign addr   = addr_q;
    assign done   = done_q;

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q); // R8

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        (mem_fire && inc_q && active_q && !abort) |=>
            addr_q == $past(addr_q) + ADDR_W'(beat_bytes($past(wid_q)))); // R7

    AST_MISALIGNED_IDLE: assert property (@(posedge clk) disable iff (rst)
        (go && !active_q && start_addr[ALIGN_BITS-1:0] != '0) |=> !active_q); // R9

    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (rst)
        abort |=> (!active_q && !done_q)); // R10

endmodule

// File: rtl/sddma_hold.sv
module sddma_hold #(
    parameter int DW = 64
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          load,
    input  logic [DW-1:0] din,
    input  logic          unload,
    output logic          full,
    output logic [DW-1:0] dout
);

    logic          full_q;
    logic [DW-1:0] data_q;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            full_q <= 1'b0;
        end else if (load) begin
            full_q <= 1'b1;
        end else if (unload) begin
            full_q <= 1'b0;
        end
        if (load)
            data_q <= din;
    end

    assign full = full_q;
    assign dout = data_q;

    AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (rst)
        !(load && full_q)); // R5

endmodule

// File: rtl/sddma_channel.sv
module sddma_channel
    import sddma_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int CNT_W  = 16,
    parameter int BSZ_W  = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [7:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [CNT_W-1:0]  blk_count,
    input  logic [BSZ_W-1:0]  blk_size,
    output logic              mem_req,
    output logic              mem_we,
    output logic [63:0]       mem_addr,
    output logic [1:0]        mem_size,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_gnt,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [DATA_W-1:0] tx_data,
    input  logic              rx_valid,
    output logic              rx_ready,
    input  logic [DATA_W-1:0] rx_data,
    output logic              busy,
    output logic              done
);

    localparam int ADDR_W = 64;

    mode_t             mode;
    logic [ADDR_W-1:0] start_addr;
    logic              go;
    logic [1:0]        ch_run;

    logic              active, dir, can_take, abort;
    wid_e              wid;
    logic [ADDR_W-1:0] addr;
    logic              in_fire, out_fire, mem_fire;
    logic              full;
    logic [DATA_W-1:0] hold_data, hold_din;

    sddma_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (reg_wr),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .rdata      (reg_rdata),
        .mode       (mode),
        .start_addr (start_addr),
        .go         (go),
        .ch_run     (ch_run)
    );

    sddma_engine #(
        .CNT_W  (CNT_W),
        .BSZ_W  (BSZ_W),
        .ADDR_W (ADDR_W)
    ) u_engine (
        .clk        (clk),
        .rst        (rst),
        .go         (go),
        .mode       (mode),
        .start_addr (start_addr),
        .ch_run     (ch_run),
        .blk_count  (blk_count),
        .blk_size   (blk_size),
        .in_fire    (in_fire),
        .out_fire   (out_fire),
        .mem_fire   (mem_fire),
        .active     (active),
        .dir        (dir),
        .wid        (wid),
        .addr       (addr),
        .can_take   (can_take),
        .abort      (abort),
        .done       (done)
    );

    sddma_hold #(.DW(DATA_W)) u_hold (
        .clk    (clk),
        .rst    (rst),
        .flush  (abort || !active),
        .load   (in_fire),
        .din    (hold_din),
        .unload (out_fire),
        .full   (full),
        .dout   (hold_data)
    );

    // direction 0: memory feeds the holding register, stream drains it
    // direction 1: stream feeds the holding register, memory drains it
    always_comb begin
        if (dir) begin
            mem_req  = full && active && !abort;
            rx_ready = can_take && !full;
            tx_valid = 1'b0;
            in_fire  = rx_valid && rx_ready;
            out_fire = mem_req && mem_gnt;
            hold_din = rx_data;
        end else begin
            mem_req  = can_take && !full;
            rx_ready = 1'b0;
            tx_valid = full && active && !abort;
            in_fire  = mem_req && mem_gnt;
            out_fire = tx_valid && tx_ready;
            hold_din = mem_rdata;
        end
        mem_fire = mem_req && mem_gnt;
    end

    assign mem_we    = dir && mem_req;
    assign mem_addr  = addr;
    assign mem_size  = wid;
    assign mem_wdata = hold_data;
    assign tx_data   = hold_data;
    assign busy      = active;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst || abort)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr))); // R11

    AST_STREAM_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
        (tx_valid || rx_ready || mem_req) |-> busy); // R10

endmodule

// File: tb/sddma_channel_test.sv
module sddma_channel_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [15:0] blk_count = '0;
    logic [11:0] blk_size = '0;
    logic        mem_req, mem_we;
    logic [63:0] mem_addr, mem_wdata, mem_rdata;
    logic [1:0]  mem_size;
    logic        mem_gnt = 1'b0;
    logic        tx_valid, rx_ready, busy, done;
    logic        tx_ready = 1'b0;
    logic        rx_valid = 1'b0;
    logic [63:0] tx_data;
    logic [63:0] rx_data = '0;

    always #10 clk = ~clk;

    sddma_channel uut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .blk_count(blk_count), .blk_size(blk_size),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_gnt(mem_gnt),
        .mem_rdata(mem_rdata), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_data(tx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .rx_data(rx_data), .busy(busy), .done(done)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // transfer under test
    bit          x_dir, x_inc;
    int          x_wid;
    logic [63:0] x_base;
    int mem_idx = 0, tx_idx = 0, rx_idx = 0, done_cnt = 0;
    bit pend_prev = 0, done_prev = 0, abort_expect = 0;
    logic [63:0] pend_addr;

    function automatic logic [63:0] mem_word(input logic [63:0] a);
        return {a[31:0] ^ 32'hA5C3_0F1E, ~a[31:0]};
    endfunction

    function automatic logic [63:0] rx_word(input int k);
        return {32'h5EED_0000 + 32'(k), 32'(k) * 32'h0101_0101};
    endfunction

    function automatic logic [63:0] exp_addr(input int k);
        return x_inc ? x_base + 64'(k) * (64'd1 << x_wid) : x_base;
    endfunction

    function automatic int exp_beats(input int cnt, input int size, input int w);
        int bb;
        bb = 1 << w;
        return (cnt * size + bb - 1) / bb;
    endfunction

    assign mem_rdata = mem_word(mem_addr);

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // handshake driver and beat monitor
    initial begin
        forever begin
            @(negedge clk);
            mem_gnt  = ($urandom % 4) != 0;
            tx_ready = ($urandom % 3) != 0;
            rx_valid = ($urandom % 3) != 0;
            rx_data  = rx_word(rx_idx);
            #1;
            if (pend_prev && !abort_expect && !rst)
                chk(mem_req && mem_addr == pend_addr, "R11 held request", mem_addr, pend_addr);
            pend_prev = mem_req && !mem_gnt;
            pend_addr = mem_addr;
            if (mem_req && mem_gnt) begin
                chk(mem_addr == exp_addr(mem_idx), "R7 beat address", mem_addr, exp_addr(mem_idx));
                if (x_dir) begin
                    chk(mem_we == 1'b1, "R6 write enable", 64'(mem_we), 64'd1);
                    chk(mem_wdata == rx_word(mem_idx), "R6 write data", mem_wdata, rx_word(mem_idx));
                end else begin
                    chk(mem_we == 1'b0, "R5 read beat", 64'(mem_we), 64'd0);
                end
                mem_idx++;
            end
            if (tx_valid && tx_ready) begin
                chk(tx_data == mem_word(exp_addr(tx_idx)), "R5 stream data",
                    tx_data, mem_word(exp_addr(tx_idx)));
                tx_idx++;
            end
            if (rx_valid && rx_ready) rx_idx++;
            if (done && done_prev)
                chk(1'b0, "R8 done longer than one cycle", 64'd2, 64'd1);
            done_prev = done;
            if (done) done_cnt++;
        end
    end

    task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); #5;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); #5;
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); #5;
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic setup(input bit dir, input int w, input bit inc, input int cnt,
                         input int size, input logic [63:0] base);
        @(negedge clk); #5;
        x_dir = dir; x_wid = w; x_inc = inc; x_base = base;
        mem_idx = 0; tx_idx = 0; rx_idx = 0;
        blk_count = 16'(cnt); blk_size = 12'(size);
        reg_write(8'h00, (32'(dir) << 16) | (32'(w) << 4) | 32'(inc));
        reg_write(8'h10, base[31:0]);
        reg_write(8'h14, base[63:32]);
    endtask

    task automatic run_xfer(input bit dir, input int w, input bit inc, input int cnt,
                            input int size, input logic [63:0] base);
        int beats, d0;
        logic [31:0] rd;
        beats = exp_beats(cnt, size, w);
        setup(dir, w, inc, cnt, size, base);
        d0 = done_cnt;
        reg_write(8'h04, 32'h1);
        reg_read(8'h04, rd);
        chk(rd == 32'h0, "R3 start bit self clears", 64'(rd), 64'd0);
        for (int i = 0; i < 20000 && done_cnt == d0; i++) @(negedge clk);
        @(negedge clk); #5;
        chk(done_cnt - d0 == 1, "R8 one done pulse", 64'(done_cnt - d0), 64'd1);
        chk(busy == 1'b0, "R8 busy low after done", 64'(busy), 64'd0);
        chk(mem_idx == beats, "R4 memory beats", 64'(mem_idx), 64'(beats));
        if (dir) chk(rx_idx == beats, "R4 stream beats in", 64'(rx_idx), 64'(beats));
        else     chk(tx_idx == beats, "R4 stream beats out", 64'(tx_idx), 64'(beats));
    endtask

    task automatic try_ignored(input string req, input bit dir, input int dirfield,
                               input int cnt, input int size, input logic [63:0] base);
        int d0;
        setup(dir, 3, 1, cnt, size, base);
        if (dirfield > 1) reg_write(8'h00, (32'(dirfield) << 16) | 32'h31);
        d0 = done_cnt;
        reg_write(8'h04, 32'h1);
        repeat (4) @(negedge clk);
        #5;
        chk(busy == 1'b0, req, 64'(busy), 64'd0);
        chk(mem_idx == 0 && tx_idx == 0 && rx_idx == 0 && done_cnt == d0, req,
            64'(mem_idx + tx_idx + rx_idx), 64'd0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        int mi, dc;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #5;
        // reset state
        chk(busy == 0 && done == 0 && mem_req == 0, "R2 reset outputs idle",
            64'({busy, done, mem_req}), 64'd0);
        reg_read(8'h00, rd); chk(rd == 0, "R2 reset mode", 64'(rd), 64'd0);
        reg_read(8'h10, rd); chk(rd == 0, "R2 reset addr low", 64'(rd), 64'd0);
        reg_read(8'h14, rd); chk(rd == 0, "R2 reset addr high", 64'(rd), 64'd0);
        reg_read(8'h08, rd); chk(rd == 32'h300, "R10 reset channel bits", 64'(rd), 64'h300);

        // register fields
        reg_write(8'h00, 32'hFFFF_FFFF);
        reg_read(8'h00, rd); chk(rd == 32'h0003_0031, "R1 mode mask", 64'(rd), 64'h30031);
        reg_write(8'h10, 32'h1234_5678);
        reg_write(8'h14, 32'h9ABC_DEF0);
        reg_read(8'h10, rd); chk(rd == 32'h1234_5678, "R2 addr low", 64'(rd), 64'h12345678);
        reg_read(8'h14, rd); chk(rd == 32'h9ABC_DEF0, "R2 addr high", 64'(rd), 64'h9ABCDEF0);

        // directed transfers
        run_xfer(0, 3, 1, 1, 3, 64'h0000_0000_0000_1000);   // partial beat rounds up
        run_xfer(1, 0, 1, 2, 5, 64'h0000_0001_0000_0040);
        run_xfer(0, 2, 0, 3, 8, 64'h0000_0000_00AB_CD08);   // fixed address
        run_xfer(1, 3, 1, 2, 16, 64'h0000_0000_FFFF_FFF8);  // carry into high word
        run_xfer(0, 1, 1, 1, 1, 64'h7000_0000_0000_0010);

        // constrained random transfers
        for (int n = 0; n < 12; n++) begin
            run_xfer(1'($urandom % 2), int'($urandom % 4), 1'($urandom % 2),
                     1 + int'($urandom % 3), 1 + int'($urandom % 40),
                     {$urandom, $urandom} & ~64'h7);
        end

        // ignored starts
        try_ignored("R9 misaligned start ignored", 0, 0, 2, 16, 64'h0000_0000_0000_2004);
        try_ignored("R9 zero length ignored", 1, 1, 0, 16, 64'h0000_0000_0000_2000);
        try_ignored("R9 reserved direction ignored", 0, 2, 2, 16, 64'h0000_0000_0000_2000);
        reg_write(8'h08, 32'h100);
        try_ignored("R10 start on held channel ignored", 1, 1, 2, 16, 64'h0000_0000_0000_3000);
        reg_write(8'h08, 32'h300);

        // abort mid transfer
        setup(0, 0, 1, 8, 64, 64'h0000_0000_0000_8000);
        dc = done_cnt;
        reg_write(8'h04, 32'h1);
        repeat (20) @(negedge clk);
        #5;
        chk(busy == 1'b1, "R10 busy before abort", 64'(busy), 64'd1);
        abort_expect = 1;
        reg_write(8'h08, 32'h200);
        @(negedge clk); #5;
        chk(busy == 1'b0, "R10 abort clears busy", 64'(busy), 64'd0);
        mi = mem_idx;
        repeat (6) @(negedge clk);
        #5;
        chk(mem_idx == mi && mem_req == 0, "R10 no beats after abort", 64'(mem_idx), 64'(mi));
        chk(done_cnt == dc, "R10 no done after abort", 64'(done_cnt), 64'(dc));
        reg_read(8'h08, rd); chk(rd == 32'h200, "R10 channel bit readback", 64'(rd), 64'h200);
        reg_write(8'h08, 32'h300);
        repeat (2) @(negedge clk);
        abort_expect = 0;
        run_xfer(0, 2, 1, 1, 12, 64'h0000_0000_0000_9000);  // recovers after abort

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule